// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Range Maintenance

This block sits between a processor's load/store port and a memory that moves whole lines. Each byte address is split into tag, index and offset, and the index picks exactly one line of the array. A read or write whose tag matches is served from the array in the cycle it is presented. A write only marks the line dirty and does not go to memory. On a mismatch the controller first writes the resident line out if it is dirty. It then fetches the wanted line and serves the request from the array.

A second request port walks an address range line by line and runs one of three upkeep actions on it. The first discards lines without saving them. The second writes dirty lines out and keeps them resident. The third writes dirty lines out and then drops them. The range is a start byte address and a byte count. Every line touched by any byte of the range is visited. A line is acted on only when it actually holds the walked address.

Top module: `cache_dm_wb`

## Requirements
- R1: With default parameters the byte address splits into tag = addr[11:7], index = addr[6:4] and word select = addr[3:2]. Two addresses with equal index and different tags compete for the same single line.
- R2: A read whose index holds a valid line with an equal tag raises cpu_ready in the cycle the request is presented. cpu_rdata then carries the selected word, and no memory request is made.
- R3: A write hit is acknowledged by cpu_ready in its first cycle without any memory traffic. The word is stored and the line becomes dirty.
- R4: On a miss, a valid dirty resident line is first written to memory at its own line address, and then the requested line is read. A clean or invalid resident line causes only the read. The request completes from the refilled line.
- R5: Reset leaves every line invalid and clean, so the first access to any address misses.
- R6: maint_op = 2'b10 (invalidate) drops each matching line without writing it to memory, even when it is dirty.
- R7: maint_op = 2'b01 (clean) writes each matching dirty line to memory and leaves it valid and clean. A second clean of the same range writes nothing.
- R8: maint_op = 2'b11 writes each matching dirty line to memory and then invalidates it, so the next access misses.
- R9: The walk visits every line from floor(addr/16) to floor((addr+len-1)/16). A length of zero visits no line and still completes.
- R10: The walk acts on a line only when it is valid and its stored tag equals the walked address's tag. A line at the same index that holds another tag is left unchanged.
- R11: cpu_ready stays low while a miss or a walk is in progress. maint_ready is high only when the controller is idle. maint_done is a one-cycle pulse after the last line is handled.
- R12: The memory port carries one full line per handshake (mem_valid and mem_ready both high). mem_we = 1 marks a write of mem_wline, and mem_we = 0 marks a read whose data is on mem_rline in the handshake cycle. The request stays unchanged until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address, held until cpu_ready |
| cpu_wdata | input | WORD_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | WORD_W | Read data, valid with cpu_ready |
| maint_valid | input | 1 | Range operation request |
| maint_op | input | 2 | bit0 = write dirty lines out, bit1 = invalidate |
| maint_addr | input | ADDR_W | Range start byte address |
| maint_len | input | LEN_W | Range length in bytes |
| maint_ready | output | 1 | Range request accepted this cycle |
| maint_done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned byte address |
| mem_wline | output | LINE_W | Line written to memory |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rline | input | LINE_W | Line read from memory, valid with mem_ready |

## Verification
The checker watches several rules on every cycle. cpu_ready never coincides with a memory request, and a write hit is followed by no memory access. A stalled memory request holds its address and direction. An invalidate-only walk never issues a memory write, and maint_done lasts exactly one cycle and never overlaps cpu_ready. The directed scenarios cover what depends on stored contents: victim data reaching the right memory line, data surviving or being lost after each upkeep action, the set of lines a rounded range reaches, and the rule that only the matching tag is acted on.

// File: rtl/cache_pkg.sv
package cache_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EVICT,
    ST_REFILL,
    ST_WALK,
    ST_WALK_WB,
    ST_FINISH
  } cache_state_e;

  localparam int OP_SAVE_BIT = 0;
  localparam int OP_DROP_BIT = 1;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_dirty,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [NUM_LINES-1:0] valid_q;
  logic [NUM_LINES-1:0] dirty_q;
  logic [TAG_W-1:0]     tag_q [NUM_LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (wr_en) begin
      valid_q[wr_idx] <= wr_valid;
      dirty_q[wr_idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int NUM_LINES  = 8,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32,
  parameter int IDX_W      = 3,
  parameter int WSEL_W     = 2
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             rd_idx,
  output logic [LINE_WORDS*WORD_W-1:0] rd_line,
  input  logic                         line_we,
  input  logic                         word_we,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [WSEL_W-1:0]            wr_wsel,
  input  logic [LINE_WORDS*WORD_W-1:0] wr_line,
  input  logic [WORD_W-1:0]            wr_word
);

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_bank
    logic [WORD_W-1:0] bank_q [NUM_LINES];
    logic              bank_we;

    assign bank_we = line_we || (word_we && (wr_wsel == WSEL_W'(w)));

    always_ff @(posedge clk) begin
      if (bank_we)
        bank_q[wr_idx] <= line_we ? wr_line[w*WORD_W +: WORD_W] : wr_word;
    end

    assign rd_line[w*WORD_W +: WORD_W] = bank_q[rd_idx];
  end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LEN_W      = 12,
  parameter int OFF_W      = 4,
  parameter int IDX_W      = 3,
  parameter int TAG_W      = 5,
  parameter int WSEL_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_valid,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic [WORD_W-1:0]            cpu_rdata,
  input  logic                         maint_valid,
  input  logic [1:0]                   maint_op,
  input  logic [ADDR_W-1:0]            maint_addr,
  input  logic [LEN_W-1:0]             maint_len,
  output logic                         maint_ready,
  output logic                         maint_done,
  output logic                         mem_valid,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [LINE_WORDS*WORD_W-1:0] mem_wline,
  input  logic                         mem_ready,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rline,
  output logic [IDX_W-1:0]             lk_idx,
  input  logic                         rd_valid,
  input  logic                         rd_dirty,
  input  logic [TAG_W-1:0]             rd_tag,
  input  logic [LINE_WORDS*WORD_W-1:0] rd_line,
  output logic                         tag_we,
  output logic                         tag_wvalid,
  output logic                         tag_wdirty,
  output logic [TAG_W-1:0]             tag_wtag,
  output logic                         line_we,
  output logic                         word_we,
  output logic [WSEL_W-1:0]            wsel,
  output logic                         ev_fill,
  output logic                         ev_walk,
  output logic [1:0]                   ev_walk_op
);

  localparam int LADDR_W = ADDR_W - OFF_W;
  localparam int CNT_W   = LEN_W + 1;
  localparam int BSEL_W  = OFF_W - WSEL_W;

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [WSEL_W-1:0] wsel_of(input logic [ADDR_W-1:0] a);
    return a[BSEL_W +: WSEL_W];
  endfunction

  // number of lines touched by [a, a+len)
  function automatic logic [CNT_W-1:0] span_lines(input logic [ADDR_W-1:0] a,
                                                  input logic [LEN_W-1:0]  len);
    logic [CNT_W-1:0] s;
    if (len == '0) return '0;
    s = {1'b0, len} + CNT_W'(a[OFF_W-1:0]) + CNT_W'((1 << OFF_W) - 1);
    return s >> OFF_W;
  endfunction

  cache_state_e       state_q;
  logic [ADDR_W-1:0]  req_q;
  logic [LADDR_W-1:0] walk_line_q;
  logic [CNT_W-1:0]   walk_left_q;
  logic [1:0]         walk_op_q;

  logic cpu_hit, walk_match, walk_save, advance, last_line;

  always_comb begin
    case (state_q)
      ST_EVICT, ST_REFILL:  lk_idx = idx_of(req_q);
      ST_WALK, ST_WALK_WB:  lk_idx = walk_line_q[IDX_W-1:0];
      default:              lk_idx = idx_of(cpu_addr);
    endcase
  end

  assign cpu_hit    = rd_valid && (rd_tag == tag_of(cpu_addr));
  assign cpu_ready  = (state_q == ST_IDLE) && cpu_valid && !maint_valid && cpu_hit;
  assign wsel       = wsel_of(cpu_addr);
  assign cpu_rdata  = rd_line[wsel*WORD_W +: WORD_W];
  assign maint_ready = (state_q == ST_IDLE);
  assign maint_done  = (state_q == ST_FINISH);

  assign walk_match = rd_valid && (rd_tag == walk_line_q[LADDR_W-1 -: TAG_W]);
  assign walk_save  = walk_match && rd_dirty && walk_op_q[OP_SAVE_BIT];
  assign advance    = ((state_q == ST_WALK) && !walk_save) ||
                      ((state_q == ST_WALK_WB) && mem_ready);
  assign last_line  = (walk_left_q == CNT_W'(1));

  assign mem_valid = (state_q == ST_EVICT) || (state_q == ST_REFILL) || (state_q == ST_WALK_WB);
  assign mem_we    = (state_q == ST_EVICT) || (state_q == ST_WALK_WB);
  assign mem_wline = rd_line;

  always_comb begin
    case (state_q)
      ST_EVICT:   mem_addr = {rd_tag, idx_of(req_q), {OFF_W{1'b0}}};
      ST_WALK_WB: mem_addr = {walk_line_q, {OFF_W{1'b0}}};
      default:    mem_addr = {req_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    endcase
  end

  // tag/state updates and array writes
  always_comb begin
    tag_we     = 1'b0;
    tag_wvalid = rd_valid;
    tag_wdirty = rd_dirty;
    tag_wtag   = rd_tag;
    word_we    = 1'b0;
    line_we    = 1'b0;
    case (state_q)
      ST_IDLE: if (cpu_ready && cpu_we) begin
        tag_we     = 1'b1;
        tag_wvalid = 1'b1;
        tag_wdirty = 1'b1;
        word_we    = 1'b1;
      end
      ST_REFILL: if (mem_ready) begin
        tag_we     = 1'b1;
        tag_wvalid = 1'b1;
        tag_wdirty = 1'b0;
        tag_wtag   = tag_of(req_q);
        line_we    = 1'b1;
      end
      ST_WALK: if (walk_match && !walk_save && walk_op_q[OP_DROP_BIT]) begin
        tag_we     = 1'b1;
        tag_wvalid = 1'b0;
        tag_wdirty = 1'b0;
      end
      ST_WALK_WB: if (mem_ready) begin
        tag_we     = 1'b1;
        tag_wvalid = !walk_op_q[OP_DROP_BIT];
        tag_wdirty = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_q       <= '0;
      walk_line_q <= '0;
      walk_left_q <= '0;
      walk_op_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (maint_valid) begin
            walk_line_q <= maint_addr[ADDR_W-1:OFF_W];
            walk_left_q <= span_lines(maint_addr, maint_len);
            walk_op_q   <= maint_op;
            state_q     <= (span_lines(maint_addr, maint_len) == '0) ? ST_FINISH : ST_WALK;
          end else if (cpu_valid && !cpu_hit) begin
            req_q   <= cpu_addr;
            state_q <= (rd_valid && rd_dirty) ? ST_EVICT : ST_REFILL;
          end
        end
        ST_EVICT:  if (mem_ready) state_q <= ST_REFILL;
        ST_REFILL: if (mem_ready) state_q <= ST_IDLE;
        ST_WALK, ST_WALK_WB: begin
          if (state_q == ST_WALK && walk_save) state_q <= ST_WALK_WB;
          if (advance) begin
            walk_left_q <= walk_left_q - CNT_W'(1);
            walk_line_q <= walk_line_q + LADDR_W'(1);
            state_q     <= last_line ? ST_FINISH : ST_WALK;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ev_fill    = (state_q == ST_REFILL) && mem_ready;
  assign ev_walk    = (state_q == ST_WALK) || (state_q == ST_WALK_WB);
  assign ev_walk_op = walk_op_q;

endmodule

// File: rtl/cache_dm_wb.sv
module cache_dm_wb #(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 8,
  parameter int LEN_W      = 12,
  localparam int LINE_W    = LINE_WORDS * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [WORD_W-1:0] cpu_rdata,
  input  logic              maint_valid,
  input  logic [1:0]        maint_op,
  input  logic [ADDR_W-1:0] maint_addr,
  input  logic [LEN_W-1:0]  maint_len,
  output logic              maint_ready,
  output logic              maint_done,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wline,
  input  logic              mem_ready,
  input  logic [LINE_W-1:0] mem_rline
);

  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int OFF_W  = $clog2(LINE_W / 8);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic              rd_valid, rd_dirty;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_line;
  logic              tag_we, tag_wvalid, tag_wdirty;
  logic [TAG_W-1:0]  tag_wtag;
  logic              line_we, word_we;
  logic [WSEL_W-1:0] wsel;
  logic              ev_fill, ev_walk;
  logic [1:0]        ev_walk_op;

  cache_tag_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .wr_en(tag_we), .wr_idx(lk_idx), .wr_valid(tag_wvalid),
    .wr_dirty(tag_wdirty), .wr_tag(tag_wtag)
  );

  cache_data_store #(.NUM_LINES(NUM_LINES), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W),
                     .IDX_W(IDX_W), .WSEL_W(WSEL_W)) u_data (
    .clk(clk), .rd_idx(lk_idx), .rd_line(rd_line),
    .line_we(line_we), .word_we(word_we), .wr_idx(lk_idx), .wr_wsel(wsel),
    .wr_line(mem_rline), .wr_word(cpu_wdata)
  );

  cache_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .LEN_W(LEN_W),
               .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .WSEL_W(WSEL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .maint_valid(maint_valid), .maint_op(maint_op), .maint_addr(maint_addr),
    .maint_len(maint_len), .maint_ready(maint_ready), .maint_done(maint_done),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
    .mem_ready(mem_ready), .mem_rline(mem_rline),
    .lk_idx(lk_idx), .rd_valid(rd_valid), .rd_dirty(rd_dirty), .rd_tag(rd_tag),
    .rd_line(rd_line), .tag_we(tag_we), .tag_wvalid(tag_wvalid), .tag_wdirty(tag_wdirty),
    .tag_wtag(tag_wtag), .line_we(line_we), .word_we(word_we), .wsel(wsel),
    .ev_fill(ev_fill), .ev_walk(ev_walk), .ev_walk_op(ev_walk_op)
  );

endmodule

// File: rtl/cache_dm_wb_chk.sv
module cache_dm_wb_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_ready,
  input logic              cpu_we,
  input logic              maint_done,
  input logic              mem_valid,
  input logic              mem_we,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ev_fill,
  input logic              ev_walk,
  input logic [1:0]        ev_walk_op
);

  // R11
  ready_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> !mem_valid);

  // R3
  write_hit_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we) |=> !mem_valid);

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  // R6
  drop_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_walk && ev_walk_op == 2'b10) |-> !(mem_valid && mem_we));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_done |=> !maint_done);

  // R11
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maint_done |-> !cpu_ready);

  // R4
  fill_ends_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fill |=> !mem_valid);

endmodule

bind cache_dm_wb cache_dm_wb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_we(cpu_we),
  .maint_done(maint_done), .mem_valid(mem_valid), .mem_we(mem_we),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .ev_fill(ev_fill),
  .ev_walk(ev_walk), .ev_walk_op(ev_walk_op)
);

// File: tb/sim_cache_dm_wb.sv
module sim_cache_dm_wb;

  localparam int AW = 12;
  localparam int LW = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_valid = 1'b0, cpu_we = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [31:0]   cpu_wdata = '0;
  logic          cpu_ready;
  logic [31:0]   cpu_rdata;
  logic          maint_valid = 1'b0;
  logic [1:0]    maint_op = '0;
  logic [AW-1:0] maint_addr = '0;
  logic [11:0]   maint_len = '0;
  logic          maint_ready, maint_done;
  logic          mem_valid, mem_we, mem_ready;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_wline, mem_rline;

  always #2 clk = ~clk;

  cache_dm_wb u0 (.*);

  // line memory model, one stall cycle per request
  logic [LW-1:0] mem [256];
  logic          stall_q;
  int            nrd = 0, nwr = 0;
  int            nchk = 0, nerr = 0;

  assign mem_ready = mem_valid && stall_q;
  assign mem_rline = mem[mem_addr[11:4]];

  always @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= mem_valid && !mem_ready;
    if (rst_n && mem_valid && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:4]] <= mem_wline;
        nwr <= nwr + 1;
      end else begin
        nrd <= nrd + 1;
      end
    end
  end

  function automatic logic [31:0] pat(input int line, input int w);
    return 32'hA000_0000 + line * 16 + w;
  endfunction

  localparam logic [AW-1:0] A = 12'h010;  // line 1, index 1, tag 0
  localparam logic [AW-1:0] B = 12'h090;  // line 9, index 1, tag 1
  localparam logic [AW-1:0] C = 12'h020;  // line 2, index 2

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // starts and ends on a falling edge
  task automatic cpu_access(input logic we, input logic [AW-1:0] addr, input logic [31:0] wd,
                            output logic [31:0] rd, output int waits);
    cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
    #1;
    waits = 0;
    while (!cpu_ready && waits < 100) begin
      @(negedge clk); #1;
      waits++;
    end
    rd = cpu_rdata;
    @(negedge clk);
    cpu_valid = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic maint(input logic [1:0] op, input logic [AW-1:0] addr, input logic [11:0] len,
                       output int width, output int ready_seen);
    maint_valid = 1'b1; maint_op = op; maint_addr = addr; maint_len = len;
    #1;
    chk("R11 maint_ready when idle", maint_ready, 1'b1);
    @(negedge clk);
    maint_valid = 1'b0;
    cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = A;  // probe held during the walk
    #1;
    width = 0; ready_seen = 0;
    for (int i = 0; i < 300; i++) begin
      if (maint_done) width++;
      else if (width > 0) break;
      else if (cpu_ready) ready_seen++;
      @(negedge clk); #1;
    end
    cpu_valid = 1'b0;
    @(negedge clk);
  endtask

  logic [31:0] rd;
  int w, r0, w0, dw, rs;

  task automatic t_reset();
    chk("R5 cpu_ready after reset", cpu_ready, 1'b0);
    chk("R12 mem_valid after reset", mem_valid, 1'b0);
    r0 = nrd; w0 = nwr;
    cpu_access(1'b0, A, 0, rd, w);
    chk("R5 first read misses", nrd - r0, 1);
    chk("R4 clean miss no writeback", nwr - w0, 0);
    chk("R4 refill data", rd, pat(1, 0));
  endtask

  task automatic t_hit();
    r0 = nrd;
    cpu_access(1'b0, A + 4, 0, rd, w);
    chk("R2 hit same cycle", w, 0);
    chk("R2 hit no memory read", nrd - r0, 0);
    chk("R1 word select addr[3:2]", rd, pat(1, 1));
  endtask

  task automatic t_write_hit();
    w0 = nwr;
    cpu_access(1'b1, A + 8, 32'hDEAD_0001, rd, w);
    chk("R3 write ack same cycle", w, 0);
    chk("R3 write no memory traffic", nwr - w0, 0);
    cpu_access(1'b0, A + 8, 0, rd, w);
    chk("R3 write data stored", rd, 32'hDEAD_0001);
  endtask

  task automatic t_conflict();
    r0 = nrd; w0 = nwr;
    cpu_access(1'b0, B, 0, rd, w);
    chk("R4 dirty victim written", nwr - w0, 1);
    chk("R1 victim at its own line", mem[1][95:64], 32'hDEAD_0001);
    chk("R12 whole line written", mem[1][31:0], pat(1, 0));
    chk("R4 refill after eviction", rd, pat(9, 0));
    r0 = nrd; w0 = nwr;
    cpu_access(1'b0, A + 8, 0, rd, w);
    chk("R4 clean victim not written", nwr - w0, 0);
    chk("R4 refetch sees written data", rd, 32'hDEAD_0001);
  endtask

  task automatic t_invalidate();
    cpu_access(1'b1, A, 32'h1111_1111, rd, w);
    w0 = nwr;
    maint(2'b10, A, 12'd4, dw, rs);
    chk("R6 invalidate writes nothing", nwr - w0, 0);
    chk("R11 done one cycle", dw, 1);
    chk("R11 cpu_ready low during walk", rs, 0);
    r0 = nrd;
    cpu_access(1'b0, A, 0, rd, w);
    chk("R6 access after invalidate misses", nrd - r0, 1);
    chk("R6 dirty data discarded", rd, pat(1, 0));
  endtask

  task automatic t_clean();
    cpu_access(1'b1, A + 4, 32'h2222_2222, rd, w);
    w0 = nwr;
    maint(2'b01, A, 12'd1, dw, rs);
    chk("R7 clean writes dirty line", nwr - w0, 1);
    chk("R7 memory updated", mem[1][63:32], 32'h2222_2222);
    r0 = nrd;
    cpu_access(1'b0, A + 4, 0, rd, w);
    chk("R7 line kept valid", nrd - r0, 0);
    chk("R7 data kept", rd, 32'h2222_2222);
    w0 = nwr;
    maint(2'b01, A, 12'd1, dw, rs);
    chk("R7 second clean writes nothing", nwr - w0, 0);
  endtask

  task automatic t_clean_drop();
    cpu_access(1'b1, A + 12, 32'h3333_3333, rd, w);
    w0 = nwr;
    maint(2'b11, A, 12'd16, dw, rs);
    chk("R8 dirty line written", nwr - w0, 1);
    chk("R8 memory updated", mem[1][127:96], 32'h3333_3333);
    r0 = nrd;
    cpu_access(1'b0, A + 12, 0, rd, w);
    chk("R8 line dropped", nrd - r0, 1);
    chk("R8 refetched data", rd, 32'h3333_3333);
  endtask

  task automatic t_rounding();
    cpu_access(1'b1, A, 32'h4444_4444, rd, w);
    cpu_access(1'b1, C, 32'h5555_5555, rd, w);
    w0 = nwr;
    maint(2'b01, A + 15, 12'd2, dw, rs);
    chk("R9 two-byte range spans two lines", nwr - w0, 2);
    chk("R9 second line reached", mem[2][31:0], 32'h5555_5555);
    cpu_access(1'b1, A, 32'h4444_0000, rd, w);
    w0 = nwr;
    maint(2'b01, A, 12'd0, dw, rs);
    chk("R9 zero length touches nothing", nwr - w0, 0);
    chk("R9 zero length still completes", dw, 1);
    cpu_access(1'b1, C, 32'h5555_0000, rd, w);
    w0 = nwr;
    maint(2'b01, A, 12'd16, dw, rs);
    chk("R9 aligned full line is one line", nwr - w0, 1);
    chk("R9 next line untouched", mem[2][31:0], 32'h5555_5555);
  endtask

  task automatic t_tag_match();
    cpu_access(1'b1, A + 4, 32'h6666_6666, rd, w);
    w0 = nwr;
    maint(2'b10, B, 12'd16, dw, rs);
    maint(2'b11, B, 12'd16, dw, rs);
    chk("R10 other tag not written", nwr - w0, 0);
    r0 = nrd;
    cpu_access(1'b0, A + 4, 0, rd, w);
    chk("R10 resident line kept", nrd - r0, 0);
    chk("R10 resident data kept", rd, 32'h6666_6666);
  endtask

  bit finished = 1'b0;

  initial begin
    for (int l = 0; l < 256; l++)
      for (int k = 0; k < 4; k++) mem[l][k*32 +: 32] = pat(l, k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hit();
    t_write_hit();
    t_conflict();
    t_invalidate();
    t_clean();
    t_clean_drop();
    t_rounding();
    t_tag_match();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

endmodule